// File: doc/BRIEF.md
# Quarter-Duty Multiplexed LCD Drive Sequencer

This block produces the time-multiplexed drive levels for a passive LCD with four common electrodes and twenty-two segment electrodes. It takes an 88-bit display image and a small set of control inputs. Every electrode output is a 2-bit level code: 0 is ground, 1 is one third of full scale, 2 is two thirds, and 3 is full scale. An external analog stage turns each code into a voltage.

The commons are scanned in a fixed order and the drive polarity alternates, so the panel never sees a DC component. The bias scheme can be switched between one half and one third while the block runs. The lowest-numbered segment pins, up to four of them, can instead act as static general-purpose outputs, each following one fixed image bit. Three overrides remove the display, and each behaves differently:
- segment blanking keeps the commons scanning;
- power-save stops the scan;
- the active-low inhibit input forces every pin to ground.

Top module: `lcdq_drive`

## Requirements
- R1: While `rstN` is low, every common and segment output is code 0 and the scan is held at slot 0 of the positive half.
- R2: One frame is 2 × 4 × `SLOT_CYC` clock cycles (512 by default). The positive half selects commons 0, 1, 2 and 3 in turn, `SLOT_CYC` cycles each. The negative half then repeats the same order. Outputs are registered and reflect the scan position and inputs at the previous rising edge.
- R3: The selected common is code 3 in the positive half and code 0 in the negative half. A non-selected common is code 1 (positive half) or code 2 (negative half) under third bias (`biasHalf`=0). Under half bias (`biasHalf`=1) a non-selected common is code 1 in both halves, standing for the mid level.
- R4: Segment pin n (0-based, level at `segLevel[2n+1:2n]`) shows image bit `dispImage[4n+c]` while common c is selected.
- R5: Under third bias, an "on" segment is code 0 (positive half) or code 3 (negative half). An "off" segment is code 2 (positive half) or code 1 (negative half).
- R6: Under half bias, an "on" segment is code 0 (positive half) or code 3 (negative half). An "off" segment is code 3 (positive half) or code 0 (negative half).
- R7: For a `portSel` value m from 0 to 4, segment pins 0 to m-1 become static ports. Values 5, 6 and 7 behave as 4.
- R8: A port pin k outputs code 3 when `dispImage[4k]` is 1 and code 0 otherwise, constant across the frame.
- R9: With `blankSeg`=1, every non-port segment pin shows the "off" level for the current bias and half, and the commons keep scanning.
- R10: With `powerSave`=1, all commons and non-port segment pins are code 0 and port pins keep working. The scan is held at its start, so a frame restarts at slot 0 of the positive half on exit.
- R11: With `inhibitN`=0, every common, segment and port pin is code 0, whatever the other controls are. The scan keeps running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rstN | input | 1 | Asynchronous active-low reset |
| dispImage | input | 88 | Display image, bit 4n+c for segment n at common c |
| biasHalf | input | 1 | 1 selects half bias, 0 selects third bias |
| blankSeg | input | 1 | Forces off-level waveforms on segment pins |
| powerSave | input | 1 | Stops the scan and grounds commons and segments |
| portSel | input | 3 | Number of leading segment pins used as static ports |
| inhibitN | input | 1 | Active-low forced display off |
| comLevel | output | 8 | Level codes of the four commons, 2 bits each |
| segLevel | output | 44 | Level codes of the 22 segment pins, 2 bits each |

## Verification
Every level output is registered once. Each code is therefore due one clock after the rising edge at which the scan position and control inputs were sampled. This holds for control changes too: power-save, inhibit, blanking and port selection each take effect one clock later, and a slot boundary likewise shows one clock after the edge that crosses it. The reference model in the bench evaluates the requirements at every rising edge from its own frame counter. That counter is cleared on the same edges as the block's scan: under reset and during power-save. The outputs are compared at the following falling edge, so each expected value lands on exactly the cycle in which the registered result appears.

// File: rtl/lcdq_pkg.sv
package lcdq_pkg;
  parameter int LCDQ_COMS = 4;

  typedef logic [1:0] lvl_t;

  localparam lvl_t LVL_ZERO = 2'd0;
  localparam lvl_t LVL_LOW  = 2'd1;
  localparam lvl_t LVL_HIGH = 2'd2;
  localparam lvl_t LVL_FULL = 2'd3;

  // Strobes from the scan control to the level datapath
  typedef struct packed {
    logic                 negHalf;
    logic [LCDQ_COMS-1:0] comSel;
  } scanStrobe_t;
endpackage

// File: rtl/lcdq_scan_ctrl.sv
module lcdq_scan_ctrl
  import lcdq_pkg::*;
#(
  parameter int SLOT_CYC = 64
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        powerSave,
  output scanStrobe_t strobe
);
  localparam int CYC_W  = (SLOT_CYC > 1) ? $clog2(SLOT_CYC) : 1;
  localparam int SLOT_W = (LCDQ_COMS > 1) ? $clog2(LCDQ_COMS) : 1;
  localparam logic [CYC_W-1:0]  CYC_LAST  = CYC_W'(SLOT_CYC - 1);
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(LCDQ_COMS - 1);

  logic [CYC_W-1:0]     cycCnt;
  logic [SLOT_W-1:0]    slotIdx;
  logic                 negHalf;
  logic [LCDQ_COMS-1:0] selVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cycCnt  <= '0;
      slotIdx <= '0;
      negHalf <= 1'b0;
    end else if (powerSave) begin
      cycCnt  <= '0;
      slotIdx <= '0;
      negHalf <= 1'b0;
    end else if (cycCnt == CYC_LAST) begin
      cycCnt <= '0;
      if (slotIdx == SLOT_LAST) begin
        slotIdx <= '0;
        negHalf <= ~negHalf;
      end else begin
        slotIdx <= slotIdx + 1'b1;
      end
    end else begin
      cycCnt <= cycCnt + 1'b1;
    end
  end

  for (genvar c = 0; c < LCDQ_COMS; c++) begin : g_sel
    assign selVec[c] = (slotIdx == SLOT_W'(c));
  end

  assign strobe.negHalf = negHalf;
  assign strobe.comSel  = selVec;
endmodule

// File: rtl/lcdq_level_path.sv
module lcdq_level_path
  import lcdq_pkg::*;
#(
  parameter int NUM_SEG  = 22,
  parameter int NUM_PORT = 4,
  localparam int IMG_W   = LCDQ_COMS * NUM_SEG,
  localparam int PSEL_W  = $clog2(NUM_PORT + 1)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  scanStrobe_t            strobe,
  input  logic [IMG_W-1:0]       dispImage,
  input  logic                   biasHalf,
  input  logic                   blankSeg,
  input  logic                   powerSave,
  input  logic [PSEL_W-1:0]      portSel,
  input  logic                   inhibitN,
  output logic [2*LCDQ_COMS-1:0] comLevel,
  output logic [2*NUM_SEG-1:0]   segLevel
);
  logic [2*LCDQ_COMS-1:0] comNext;
  logic [2*NUM_SEG-1:0]   segNext;

  function automatic lvl_t comWave(input logic sel, input logic neg, input logic half);
    if (sel)       return neg ? LVL_ZERO : LVL_FULL;
    else if (half) return LVL_LOW;
    else           return neg ? LVL_HIGH : LVL_LOW;
  endfunction

  function automatic lvl_t segWave(input logic on, input logic neg, input logic half);
    if (on)        return neg ? LVL_FULL : LVL_ZERO;
    else if (half) return neg ? LVL_ZERO : LVL_FULL;
    else           return neg ? LVL_LOW  : LVL_HIGH;
  endfunction

  logic scanLive;
  assign scanLive = inhibitN && !powerSave;

  for (genvar c = 0; c < LCDQ_COMS; c++) begin : g_com
    assign comNext[2*c +: 2] = scanLive ? comWave(strobe.comSel[c], strobe.negHalf, biasHalf)
                                        : LVL_ZERO;
  end

  for (genvar n = 0; n < NUM_SEG; n++) begin : g_seg
    logic segBit;
    logic segOn;
    lvl_t waveLvl;
    assign segBit  = |(dispImage[LCDQ_COMS*n +: LCDQ_COMS] & strobe.comSel);
    assign segOn   = segBit && !blankSeg;
    assign waveLvl = scanLive ? segWave(segOn, strobe.negHalf, biasHalf) : LVL_ZERO;

    if (n < NUM_PORT) begin : g_shared
      logic portEn;
      assign portEn = inhibitN && (int'(portSel) > n);
      assign segNext[2*n +: 2] = portEn ? (dispImage[LCDQ_COMS*n] ? LVL_FULL : LVL_ZERO)
                                        : waveLvl;
    end else begin : g_plain
      assign segNext[2*n +: 2] = waveLvl;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      comLevel <= '0;
      segLevel <= '0;
    end else begin
      comLevel <= comNext;
      segLevel <= segNext;
    end
  end
endmodule

// File: rtl/lcdq_drive.sv
module lcdq_drive
  import lcdq_pkg::*;
#(
  parameter int NUM_SEG  = 22,
  parameter int NUM_PORT = 4,
  parameter int SLOT_CYC = 64,
  localparam int IMG_W   = LCDQ_COMS * NUM_SEG,
  localparam int PSEL_W  = $clog2(NUM_PORT + 1)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [IMG_W-1:0]       dispImage,
  input  logic                   biasHalf,
  input  logic                   blankSeg,
  input  logic                   powerSave,
  input  logic [PSEL_W-1:0]      portSel,
  input  logic                   inhibitN,
  output logic [2*LCDQ_COMS-1:0] comLevel,
  output logic [2*NUM_SEG-1:0]   segLevel
);
  scanStrobe_t strobe;

  lcdq_scan_ctrl #(.SLOT_CYC(SLOT_CYC)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .powerSave (powerSave),
    .strobe    (strobe)
  );

  lcdq_level_path #(.NUM_SEG(NUM_SEG), .NUM_PORT(NUM_PORT)) u_path (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .dispImage (dispImage),
    .biasHalf  (biasHalf),
    .blankSeg  (blankSeg),
    .powerSave (powerSave),
    .portSel   (portSel),
    .inhibitN  (inhibitN),
    .comLevel  (comLevel),
    .segLevel  (segLevel)
  );
endmodule

// File: rtl/lcdq_drive_chk.sv
module lcdq_drive_chk
  import lcdq_pkg::*;
#(
  parameter int NUM_SEG  = 22,
  parameter int NUM_PORT = 4,
  localparam int PSEL_W  = $clog2(NUM_PORT + 1)
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   powerSave,
  input logic                   blankSeg,
  input logic                   inhibitN,
  input logic [PSEL_W-1:0]      portSel,
  input logic                   imgBit0,
  input logic [2*LCDQ_COMS-1:0] comLevel,
  input logic [2*NUM_SEG-1:0]   segLevel
);
  logic                 armed;
  logic [LCDQ_COMS-1:0] comExtreme;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  for (genvar c = 0; c < LCDQ_COMS; c++) begin : g_ext
    assign comExtreme[c] = (comLevel[2*c +: 2] == LVL_ZERO) || (comLevel[2*c +: 2] == LVL_FULL);
  end

  // R11: inhibit grounds every pin on the next cycle
  assert_inhibit_ground_R11: assert property (@(posedge clk) disable iff (!rstN)
    (armed && !$past(inhibitN)) |-> (comLevel == '0 && segLevel == '0));

  // R10: power-save grounds the commons
  assert_powersave_com_R10: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(inhibitN) && $past(powerSave)) |-> (comLevel == '0));

  // R3: exactly one common sits at a rail while scanning
  assert_one_selected_R3: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(inhibitN) && !$past(powerSave)) |-> ($countones(comExtreme) == 1));

  // R8: first shared pin as port follows its image bit
  assert_port_follow_R8: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(inhibitN) && ($past(portSel) != '0))
      |-> (segLevel[1:0] == ($past(imgBit0) ? LVL_FULL : LVL_ZERO)));

  // R9: blanked segments all show the same off level
  assert_blank_uniform_R9: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(inhibitN) && !$past(powerSave) && $past(blankSeg) && ($past(portSel) == '0))
      |-> (segLevel == {NUM_SEG{segLevel[1:0]}}));
endmodule

bind lcdq_drive lcdq_drive_chk #(.NUM_SEG(NUM_SEG), .NUM_PORT(NUM_PORT)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .powerSave (powerSave),
  .blankSeg  (blankSeg),
  .inhibitN  (inhibitN),
  .portSel   (portSel),
  .imgBit0   (dispImage[0]),
  .comLevel  (comLevel),
  .segLevel  (segLevel)
);

// File: tb/sim_lcdq_drive.sv
`timescale 1ns/1ps
module sim_lcdq_drive;
  localparam int NSEG  = 22;
  localparam int NCOM  = 4;
  localparam int SLOT  = 64;
  localparam int FRAME = 2 * NCOM * SLOT;
  localparam logic [87:0] PAT_A = 88'hA53C960FE17B48D2196EC3;
  localparam logic [87:0] PAT_B = 88'h5E0771C2B8F4093DA6611F;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [87:0] dispImage = '0;
  logic        biasHalf = 1'b0;
  logic        blankSeg = 1'b0;
  logic        powerSave = 1'b0;
  logic [2:0]  portSel = '0;
  logic        inhibitN = 1'b1;
  logic [7:0]  comLevel;
  logic [43:0] segLevel;

  always #2.5 clk = ~clk;

  lcdq_drive u0 (
    .clk(clk), .rstN(rstN), .dispImage(dispImage), .biasHalf(biasHalf),
    .blankSeg(blankSeg), .powerSave(powerSave), .portSel(portSel),
    .inhibitN(inhibitN), .comLevel(comLevel), .segLevel(segLevel)
  );

  int    nChecks = 0;
  int    nFails  = 0;
  bit    done    = 0;
  string comTag  = "R1";
  string segTag  = "R1";
  int    mcnt    = 0;
  logic [7:0]  expCom = '0;
  logic [43:0] expSeg = '0;

  // Behavioural reference, evaluated at each rising edge
  always @(posedge clk) begin
    if (!rstN) begin
      mcnt   = 0;
      expCom = '0;
      expSeg = '0;
    end else begin
      int slot;
      bit neg;
      slot = (mcnt / SLOT) % NCOM;
      neg  = ((mcnt / (SLOT * NCOM)) % 2) == 1;
      for (int c = 0; c < NCOM; c++) begin
        int v;
        if (!inhibitN || powerSave) v = 0;
        else if (c == slot) v = neg ? 0 : 3;
        else if (biasHalf) v = 1;
        else v = neg ? 2 : 1;
        expCom[2*c +: 2] = 2'(v);
      end
      for (int p = 0; p < NSEG; p++) begin
        int v;
        bit on;
        on = dispImage[4*p + slot] && !blankSeg;
        if (!inhibitN) v = 0;
        else if (p < 4 && int'(portSel) > p) v = dispImage[4*p] ? 3 : 0;
        else if (powerSave) v = 0;
        else if (on) v = neg ? 3 : 0;
        else if (biasHalf) v = neg ? 0 : 3;
        else v = neg ? 1 : 2;
        expSeg[2*p +: 2] = 2'(v);
      end
      mcnt = powerSave ? 0 : (mcnt + 1) % FRAME;
    end
  end

  // Compare away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      nChecks++;
      if (comLevel !== expCom) begin
        nFails++;
        $display("FAIL %s commons: actual %h expected %h at %0t", comTag, comLevel, expCom, $time);
      end
      nChecks++;
      if (segLevel !== expSeg) begin
        nFails++;
        $display("FAIL %s segments: actual %h expected %h at %0t", segTag, segLevel, expSeg, $time);
      end
    end
  end

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finishRun();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual hung expected finish");
      finishRun();
    end
  end

  initial begin
    // R1: reset state
    comTag = "R1"; segTag = "R1";
    dispImage = PAT_A;
    portSel = 3'd4;
    run(6);
    portSel = 3'd0;
    @(negedge clk) rstN = 1'b1;

    // R2 frame timing and R5 third-bias segment levels
    comTag = "R2"; segTag = "R5";
    run(2 * FRAME + 30);

    // R4: walking single image bit
    comTag = "R3"; segTag = "R4";
    for (int k = 0; k < 88; k += 7) begin
      dispImage = 88'd1 << k;
      run(FRAME + 9);
    end

    // R6: half bias
    comTag = "R3"; segTag = "R6";
    biasHalf = 1'b1;
    dispImage = PAT_B;
    run(2 * FRAME + 40);
    biasHalf = 1'b0;

    // R7: every port selection code, including 5..7
    segTag = "R7";
    dispImage = PAT_A;
    for (int m = 0; m < 8; m++) begin
      portSel = 3'(m);
      run(300);
    end

    // R8: port pins follow image bits
    segTag = "R8";
    portSel = 3'd4;
    dispImage = PAT_B;
    run(200);
    dispImage = ~PAT_B;
    run(200);

    // R9: blanking with two ports, both biases
    segTag = "R9";
    blankSeg = 1'b1;
    portSel = 3'd2;
    run(600);
    biasHalf = 1'b1;
    run(600);
    blankSeg = 1'b0;
    biasHalf = 1'b0;

    // R10: power save with three ports, then restart
    comTag = "R10"; segTag = "R10";
    portSel = 3'd3;
    powerSave = 1'b1;
    run(300);
    dispImage = PAT_A;
    run(100);
    powerSave = 1'b0;
    run(FRAME + 100);

    // R11: inhibit overrides ports, power save and blanking
    comTag = "R11"; segTag = "R11";
    portSel = 3'd4;
    inhibitN = 1'b0;
    run(300);
    powerSave = 1'b1;
    blankSeg = 1'b1;
    run(100);
    powerSave = 1'b0;
    blankSeg = 1'b0;
    run(77);
    inhibitN = 1'b1;
    run(FRAME + 50);

    finishRun();
  end
endmodule